// File: doc/BRIEF.md
# Memory Field Extension Controller

This block widens the address reach of a processor with 12-bit word addresses from 4K words to 32K words. Memory is treated as eight fields of 4K words each. The block keeps two 3-bit field registers. One selects the field for instruction work. The other selects the field for indirect data work. For every memory cycle it places the selected field number above the 12-bit effective address, which yields a 15-bit physical address.

The processor decoder tells the block three things: the kind of each memory cycle, when a field-change command has been decoded, and when a jump has completed. A field number can come from bits coded in the instruction or from the accumulator. A data-field change takes effect at once. An instruction-field change is first held in a buffer register and reaches the active instruction field only when the next jump completes. This lets the code that issues the change keep fetching from the old field until it jumps. No status output shows whether an instruction-field change is waiting. Read ports for the three registers are provided for observation.

Top module: `mem_field_ext`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, if_q, df_q and ib_q read 0 and no instruction-field change is waiting.
- R2: When cyc_kind is 0 (fetch), 1 (direct operand) or 3 (spare, treated as direct), phys_addr[14:12] equals if_q.
- R3: When cyc_kind is 2 (indirect operand), phys_addr[14:12] equals df_q.
- R4: phys_addr[11:0] always equals eff_addr in the same cycle. The address path is combinational and adds no register.
- R5: A clock edge with df_chg high loads the selected field value into df_q. Addresses of indirect cycles use the new value from the next cycle on.
- R6: A clock edge with if_chg high and jump_done low loads the selected field value into ib_q and leaves if_q unchanged. if_q changes on no edge where jump_done is low.
- R7: A clock edge with jump_done high and if_chg low copies ib_q into if_q if a change is waiting, and then clears the waiting state.
- R8: If two or more instruction-field changes arrive before a jump, the jump installs the value of the last one.
- R9: The selected field value is acc_fld when fld_from_acc is 1, and fld_code when it is 0.
- R10: A clock edge with both if_chg and jump_done high loads the selected field value into if_q and ib_q together and leaves nothing waiting.
- R11: A jump with no change waiting leaves if_q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_kind | input | 2 | Memory cycle kind: 0 fetch, 1 direct, 2 indirect, 3 spare (treated as direct) |
| eff_addr | input | 12 | Effective word address within a field |
| if_chg | input | 1 | Change-instruction-field command decoded this cycle |
| df_chg | input | 1 | Change-data-field command decoded this cycle |
| fld_from_acc | input | 1 | Take the field value from the accumulator instead of the instruction bits |
| fld_code | input | 3 | Field value coded in the instruction |
| acc_fld | input | 3 | Field value taken from the accumulator |
| jump_done | input | 1 | A jump instruction completes at this edge |
| phys_addr | output | 15 | Physical word address |
| if_q | output | 3 | Active instruction field |
| df_q | output | 3 | Active data field |
| ib_q | output | 3 | Instruction-field buffer |

## Verification
The assertions assume that the decoder holds its command strobes and field inputs steady across each clock edge, and that cyc_kind and eff_addr are settled before the address is used. They accept any mix of commands in one cycle, including a field change that coincides with a jump. The stimulus changes every input only on the falling edge. It samples outputs just before the next rising edge. It sweeps every field value through both sources and every cycle kind, and it covers coincident change and jump commands as well as repeated changes before a jump.

// File: rtl/mfx_pkg.sv
// Package mfx_pkg: shared widths and the memory cycle kind encoding used by
// the field extension controller. Assumes a 12-bit word offset and 3-bit fields.
package mfx_pkg;
    localparam int unsigned OFS_W_DEF = 12;
    localparam int unsigned FLD_W_DEF = 3;

    typedef enum logic [1:0] {
        CYC_FETCH    = 2'd0,
        CYC_DIRECT   = 2'd1,
        CYC_INDIRECT = 2'd2,
        CYC_SPARE    = 2'd3
    } cyc_kind_t;
endpackage

// File: rtl/mfx_field_src.sv
// Module mfx_field_src: picks the field number carried by a change command,
// either from the instruction bits or from the accumulator.
// Assumes both sources are valid whenever a change command is asserted.
module mfx_field_src #(
    parameter int unsigned FW = 3
) (
    input  logic          from_acc,
    input  logic [FW-1:0] code_fld,
    input  logic [FW-1:0] acc_fld,
    output logic [FW-1:0] sel_fld
);
    // Select the field value source.
    always_comb begin
        sel_fld = from_acc ? acc_fld : code_fld;
    end
endmodule

// File: rtl/mfx_field_regs.sv
// Module mfx_field_regs: holds the active instruction field, the buffer for a
// deferred instruction-field change with its waiting flag, and the data field.
// Assumes commands and the jump strobe are single-cycle pulses from the decoder.
module mfx_field_regs #(
    parameter int unsigned FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_chg,
    input  logic          df_chg,
    input  logic          jump_done,
    input  logic [FW-1:0] new_fld,
    output logic [FW-1:0] if_fld,
    output logic [FW-1:0] df_fld,
    output logic [FW-1:0] ib_fld
);
    logic if_wait;

    // Data field: loads on the edge where its change command is decoded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            df_fld <= '0;
        end else if (df_chg) begin
            df_fld <= new_fld;
        end
    end

    // Instruction-field buffer: keeps the most recent requested field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib_fld <= '0;
        end else if (if_chg) begin
            ib_fld <= new_fld;
        end
    end

    // Active instruction field and waiting flag: the change commits at a jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_fld  <= '0;
            if_wait <= 1'b0;
        end else if (if_chg && jump_done) begin
            if_fld  <= new_fld;
            if_wait <= 1'b0;
        end else if (if_chg) begin
            if_wait <= 1'b1;
        end else if (jump_done && if_wait) begin
            if_fld  <= ib_fld;
            if_wait <= 1'b0;
        end
    end
endmodule

// File: rtl/mfx_addr_form.sv
// Module mfx_addr_form: chooses the field for the current cycle kind and
// places it above the effective address. Purely combinational.
// Assumes the cycle kind encoding from mfx_pkg; the spare code acts as direct.
module mfx_addr_form #(
    parameter int unsigned OFS_W = 12,
    parameter int unsigned FW    = 3
) (
    input  mfx_pkg::cyc_kind_t   kind,
    input  logic [OFS_W-1:0]     offset,
    input  logic [FW-1:0]        if_fld,
    input  logic [FW-1:0]        df_fld,
    output logic [OFS_W+FW-1:0]  phys
);
    logic [FW-1:0] use_fld;

    // Pick the field register that governs this cycle kind.
    always_comb begin
        unique case (kind)
            mfx_pkg::CYC_INDIRECT: use_fld = df_fld;
            default:               use_fld = if_fld;
        endcase
    end

    // Join the field number and the effective address.
    always_comb begin
        phys = {use_fld, offset};
    end
endmodule

// File: rtl/mem_field_ext.sv
// Module mem_field_ext: top of the memory field extension controller.
// Forms a physical address from a field number and a 12-bit effective address.
// Instruction-field changes are deferred until a jump; data-field changes are immediate.
// Assumes a synchronous active-low reset and decoder strobes stable at each rising edge.
module mem_field_ext #(
    parameter int unsigned OFS_W = mfx_pkg::OFS_W_DEF,
    parameter int unsigned FW    = mfx_pkg::FLD_W_DEF,
    localparam int unsigned PA_W = OFS_W + FW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cyc_kind,
    input  logic [OFS_W-1:0] eff_addr,
    input  logic             if_chg,
    input  logic             df_chg,
    input  logic             fld_from_acc,
    input  logic [FW-1:0]    fld_code,
    input  logic [FW-1:0]    acc_fld,
    input  logic             jump_done,
    output logic [PA_W-1:0]  phys_addr,
    output logic [FW-1:0]    if_q,
    output logic [FW-1:0]    df_q,
    output logic [FW-1:0]    ib_q
);
    logic [FW-1:0]      sel_fld;
    mfx_pkg::cyc_kind_t kind;

    // Convert the raw cycle code into the enumerated kind.
    always_comb begin
        kind = mfx_pkg::cyc_kind_t'(cyc_kind);
    end

    mfx_field_src #(.FW(FW)) u_src (
        .from_acc (fld_from_acc),
        .code_fld (fld_code),
        .acc_fld  (acc_fld),
        .sel_fld  (sel_fld)
    );

    mfx_field_regs #(.FW(FW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .if_chg    (if_chg),
        .df_chg    (df_chg),
        .jump_done (jump_done),
        .new_fld   (sel_fld),
        .if_fld    (if_q),
        .df_fld    (df_q),
        .ib_fld    (ib_q)
    );

    mfx_addr_form #(.OFS_W(OFS_W), .FW(FW)) u_addr (
        .kind   (kind),
        .offset (eff_addr),
        .if_fld (if_q),
        .df_fld (df_q),
        .phys   (phys_addr)
    );
endmodule

// File: rtl/mfx_checker.sv
// Module mfx_checker: concurrent checks on the ports of mem_field_ext.
// Attached to every instance of the top module by the bind below.
module mfx_checker #(
    parameter int unsigned OFS_W = 12,
    parameter int unsigned FW    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cyc_kind,
    input logic [OFS_W-1:0]    eff_addr,
    input logic                if_chg,
    input logic                df_chg,
    input logic                fld_from_acc,
    input logic [FW-1:0]       fld_code,
    input logic [FW-1:0]       acc_fld,
    input logic                jump_done,
    input logic [OFS_W+FW-1:0] phys_addr,
    input logic [FW-1:0]       if_q,
    input logic [FW-1:0]       df_q,
    input logic [FW-1:0]       ib_q
);
    // R2: fetch, direct and spare cycles take the instruction field.
    a_r2_instr_field_used: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 2'd2) |-> (phys_addr[OFS_W+FW-1:OFS_W] == if_q));

    // R3: indirect cycles take the data field.
    a_r3_data_field_used: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd2) |-> (phys_addr[OFS_W+FW-1:OFS_W] == df_q));

    // R4: the low address bits pass through.
    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFS_W-1:0] == eff_addr);

    // R5 with R9: a data-field change lands on the next cycle.
    a_r5_df_loads: assert property (@(posedge clk) disable iff (!rst_n)
        df_chg |=> (df_q == $past(fld_from_acc ? acc_fld : fld_code)));

    // R6: the instruction field moves only at a jump.
    a_r6_if_held: assert property (@(posedge clk) disable iff (!rst_n)
        !jump_done |=> $stable(if_q));

    // R6: a deferred change lands in the buffer.
    a_r6_ib_loads: assert property (@(posedge clk) disable iff (!rst_n)
        if_chg |=> (ib_q == $past(fld_from_acc ? acc_fld : fld_code)));

    // R7: a jump alone installs the buffered field.
    a_r7_jump_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_done && !if_chg) |=> (if_q == $past(ib_q)));

    // R10: a change together with a jump installs the new field directly.
    a_r10_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_done && if_chg) |=> (if_q == $past(fld_from_acc ? acc_fld : fld_code)));
endmodule

bind mem_field_ext mfx_checker #(.OFS_W(OFS_W), .FW(FW)) u_mfx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_kind     (cyc_kind),
    .eff_addr     (eff_addr),
    .if_chg       (if_chg),
    .df_chg       (df_chg),
    .fld_from_acc (fld_from_acc),
    .fld_code     (fld_code),
    .acc_fld      (acc_fld),
    .jump_done    (jump_done),
    .phys_addr    (phys_addr),
    .if_q         (if_q),
    .df_q         (df_q),
    .ib_q         (ib_q)
);

// File: tb/test_mem_field_ext.sv
// Bench for mem_field_ext: sweeps field values, sources, cycle kinds and
// command combinations against a model built from the requirements.
module test_mem_field_ext;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cyc_kind = 2'd0;
    logic [11:0] eff_addr = 12'd0;
    logic        if_chg = 1'b0;
    logic        df_chg = 1'b0;
    logic        fld_from_acc = 1'b0;
    logic [2:0]  fld_code = 3'd0;
    logic [2:0]  acc_fld = 3'd0;
    logic        jump_done = 1'b0;
    logic [14:0] phys_addr;
    logic [2:0]  if_q, df_q, ib_q;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [2:0] m_if = 3'd0, m_df = 3'd0, m_ib = 3'd0;
    logic       m_wait = 1'b0;

    mem_field_ext i_mem_field_ext (
        .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .eff_addr(eff_addr),
        .if_chg(if_chg), .df_chg(df_chg), .fld_from_acc(fld_from_acc),
        .fld_code(fld_code), .acc_fld(acc_fld), .jump_done(jump_done),
        .phys_addr(phys_addr), .if_q(if_q), .df_q(df_q), .ib_q(ib_q)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, check before the rising edge, then update the model.
    task automatic step(input logic [1:0] k, input logic [11:0] a, input logic si,
                        input logic sd, input logic sa, input logic [2:0] imm,
                        input logic [2:0] acc, input logic j);
        logic [2:0] v;
        @(negedge clk);
        cyc_kind = k; eff_addr = a; if_chg = si; df_chg = sd;
        fld_from_acc = sa; fld_code = imm; acc_fld = acc; jump_done = j;
        #4;
        if (k == 2'd2) check("R3 indirect field", 15'(phys_addr[14:12]), 15'(m_df));
        else           check("R2 instruction field", 15'(phys_addr[14:12]), 15'(m_if));
        check("R4 offset", 15'(phys_addr[11:0]), 15'(a));
        check("R6 R7 R11 if_q", 15'(if_q), 15'(m_if));
        check("R5 df_q", 15'(df_q), 15'(m_df));
        check("R8 ib_q", 15'(ib_q), 15'(m_ib));
        @(posedge clk);
        v = sa ? acc : imm;   // R9 source selection
        if (sd) m_df = v;
        if (si) m_ib = v;
        if (si && j) begin m_if = v; m_wait = 1'b0; end      // R10
        else if (si) m_wait = 1'b1;                           // R6
        else if (j && m_wait) begin m_if = m_ib; m_wait = 1'b0; end  // R7
    endtask

    task automatic idle(input logic [1:0] k, input logic [11:0] a);
        step(k, a, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during reset and just after.
        repeat (2) @(negedge clk);
        #4;
        check("R1 if_q in reset", 15'(if_q), 15'd0);
        check("R1 df_q in reset", 15'(df_q), 15'd0);
        check("R1 ib_q in reset", 15'(ib_q), 15'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #4;
        check("R1 address after reset", phys_addr, 15'h0000);
        // R11: jump right after reset leaves field 0.
        step(2'd0, 12'h123, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1);
        idle(2'd0, 12'h456);

        // R5, R9, R3: every data field value from each source, used by indirect cycles.
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 8; f++) begin
                step(2'd2, 12'(f * 331), 1'b0, 1'b1, s[0], s[0] ? 3'(7 - f) : 3'(f),
                     s[0] ? 3'(f) : 3'(7 - f), 1'b0);
                for (int k = 0; k < 4; k++) idle(2'(k), 12'(f * 97 + k * 1021));
            end
        end

        // R6, R7, R9, R2: every instruction field through each source, deferred until a jump.
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 8; f++) begin
                step(2'd0, 12'hFFF, 1'b1, 1'b0, s[0], s[0] ? 3'(~f) : 3'(f),
                     s[0] ? 3'(f) : 3'(~f), 1'b0);
                idle(2'd1, 12'h800);
                idle(2'd3, 12'h001);
                step(2'd0, 12'h0AA, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1);
                for (int k = 0; k < 4; k++) idle(2'(k), 12'(f * 513 + k));
            end
        end

        // R8: several changes before the jump; the last one wins.
        step(2'd0, 12'h010, 1'b1, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0);
        step(2'd0, 12'h011, 1'b1, 1'b0, 1'b1, 3'd0, 3'd5, 1'b0);
        step(2'd0, 12'h012, 1'b1, 1'b0, 1'b0, 3'd6, 3'd1, 1'b0);
        step(2'd0, 12'h013, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1);
        idle(2'd0, 12'h014);
        check("R8 last change installed", 15'(if_q), 15'd6);

        // R10: change and jump on the same edge.
        step(2'd0, 12'h020, 1'b1, 1'b0, 1'b0, 3'd3, 3'd7, 1'b1);
        idle(2'd1, 12'h021);
        check("R10 direct install", 15'(if_q), 15'd3);
        // R11: following jump with nothing waiting keeps field 3.
        step(2'd0, 12'h022, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1);
        idle(2'd0, 12'h023);
        check("R11 no change on idle jump", 15'(if_q), 15'd3);

        // R5 with R6: both changes together; data now, instruction later.
        step(2'd2, 12'h030, 1'b1, 1'b1, 1'b1, 3'd0, 3'd4, 1'b0);
        idle(2'd2, 12'h031);
        idle(2'd0, 12'h032);
        step(2'd1, 12'h033, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1);
        idle(2'd0, 12'h034);

        // Mixed sweep over command combinations and cycle kinds.
        for (int n = 0; n < 256; n++) begin
            step(2'(n), 12'(n * 16 + 7), n[2], n[3], n[4], 3'(n >> 5), 3'(n), n[1] ^ n[5]);
        end

        // R1: reset in the middle of activity clears everything.
        step(2'd0, 12'h040, 1'b1, 1'b1, 1'b0, 3'd5, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        if_chg = 1'b0; df_chg = 1'b0; jump_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_if = 3'd0; m_df = 3'd0; m_ib = 3'd0; m_wait = 1'b0;
        step(2'd0, 12'h050, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1);
        idle(2'd2, 12'h051);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule